// File: doc/BRIEF.md
# Branch and Call Next-PC Selector

This block keeps the fetch address of a simple in-order sequencer and decides, every cycle, where fetch goes next. Without a control transfer the address steps forward by one instruction. A decoded jump or call sends fetch to an absolute or PC-relative target. A call also stores the address of the instruction after it in a return register.

Conditional jumps test a single condition flag, with either polarity. Each one carries a static hint. The front end follows the hinted path at decode. The jump is then held in one pending slot until a resolve strobe reports the flag. If the outcome differs from the hint, the block raises flush for that cycle and sends fetch to the correct path. A younger transfer decoded in the same cycle is discarded.

All outputs are registered. An output reflects the inputs sampled at the previous rising clock edge.

Top module: `npc_select`

## Requirements
- R1: While `rst` is high, at a clock edge `pc_q` is loaded with `RESET_VEC` (default 0x1000), `ret_q` with 0, and `flush_q` and `redir_q` are cleared.
- R2: In a cycle with no control transfer and no mispredict, `pc_q` advances by `INSN_BYTES` (default 4) and `redir_q` stays low.
- R3: An absolute jump (`dec_kind` = 1) loads `pc_q` with `dec_abs_tgt`, pulses `redir_q`, and leaves `ret_q` unchanged.
- R4: A relative jump (`dec_kind` = 2) loads `pc_q` with `dec_pc` plus the sign-extended `dec_off`. Bit 0 of the offset is treated as zero, so offsets span -4096 to +4094 bytes.
- R5: An absolute call (`dec_kind` = 3) or a relative call (`dec_kind` = 4) redirects in the same way as the matching jump and writes `dec_pc + INSN_BYTES` into `ret_q`.
- R6: A conditional jump (`dec_kind` = 5, relative target) is taken when `cc_flag` = 1 at resolve. When `dec_on_false` was set at decode, it is taken when `cc_flag` = 0 instead.
- R7: A conditional jump with `dec_hint` = 1 redirects to its target at decode. With `dec_hint` = 0 it causes no redirect at decode, and fetch continues sequentially.
- R8: A resolve whose outcome matches the hint produces no flush and no redirect.
- R9: A resolve whose outcome differs from the hint raises `flush_q` and `redir_q` for one cycle. `pc_q` and `redir_addr_q` then hold the target if the jump was taken, and the jump's `dec_pc + INSN_BYTES` if it was not.
- R10: A `res_valid` strobe with no conditional jump pending has no effect: no flush, and `pc_q` keeps its sequential step.
- R11: When a mispredict resolves in the same cycle that a jump or call is decoded, the correction wins. `pc_q` takes the corrected address and `ret_q` is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A decoded instruction is present |
| dec_kind | input | 3 | 0 none, 1 jump abs, 2 jump rel, 3 call abs, 4 call rel, 5 conditional jump rel |
| dec_pc | input | PC_W | Address of the decoded instruction |
| dec_abs_tgt | input | PC_W | Absolute target |
| dec_off | input | OFF_W | Signed byte offset for relative forms |
| dec_hint | input | 1 | Conditional jump predicted taken |
| dec_on_false | input | 1 | Conditional jump is taken on a false flag |
| res_valid | input | 1 | Resolve strobe for the pending conditional jump |
| cc_flag | input | 1 | Condition flag at resolve |
| pc_q | output | PC_W | Next fetch address |
| ret_q | output | PC_W | Return register |
| flush_q | output | 1 | Mispredict flush pulse |
| redir_q | output | 1 | Fetch redirected this cycle |
| redir_addr_q | output | PC_W | Redirect address |

## Verification
The assertions assume that at most one conditional jump is in flight. A new one is decoded only after the previous one has resolved, or in the same cycle as its resolve. They also assume that `res_valid` is only ever meant to refer to that pending jump.

The directed tasks keep to these assumptions. Each task issues one conditional jump and then resolves it before the next one is decoded. The one deliberate stray strobe is sent while nothing is pending. Under these conditions, a flush can only follow a resolve strobe, and the return register can only move after a decoded call.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    K_NONE     = 3'd0,
    K_JMP_ABS  = 3'd1,
    K_JMP_REL  = 3'd2,
    K_CALL_ABS = 3'd3,
    K_CALL_REL = 3'd4,
    K_CJMP     = 3'd5
  } xfer_kind_e;
endpackage

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int OFF_W      = 13,
  parameter int INSN_BYTES = 4
) (
  input  logic [2:0]      kind,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] abs_tgt,
  input  logic [OFF_W-1:0] off,
  output logic [PC_W-1:0] tgt,
  output logic [PC_W-1:0] fall
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);
  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] off_ext;
  logic            use_abs;

  always_comb begin
    // offsets are even: bit 0 is dropped
    off_ext = {{EXT_W{off[OFF_W-1]}}, off[OFF_W-1:1], 1'b0};
    use_abs = (xfer_kind_e'(kind) == K_JMP_ABS) || (xfer_kind_e'(kind) == K_CALL_ABS);
    tgt     = use_abs ? abs_tgt : (pc_i + off_ext);
    fall    = pc_i + STEP;
  end
endmodule

// File: rtl/npc_tracker.sv
module npc_tracker #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap,
  input  logic            cap_hint,
  input  logic            cap_on_false,
  input  logic [PC_W-1:0] cap_tgt,
  input  logic [PC_W-1:0] cap_fall,
  input  logic            res_valid,
  input  logic            cc_flag,
  output logic            mispredict,
  output logic [PC_W-1:0] fix_addr
);
  logic            pend_v;
  logic            pend_hint;
  logic            pend_on_false;
  logic [PC_W-1:0] pend_tgt;
  logic [PC_W-1:0] pend_fall;
  logic            taken;
  logic            resolve;

  always_comb begin
    resolve    = res_valid && pend_v;
    taken      = cc_flag ^ pend_on_false;
    mispredict = resolve && (taken != pend_hint);
    fix_addr   = taken ? pend_tgt : pend_fall;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v        <= 1'b0;
      pend_hint     <= 1'b0;
      pend_on_false <= 1'b0;
      pend_tgt      <= '0;
      pend_fall     <= '0;
    end else begin
      if (resolve) pend_v <= 1'b0;
      // a younger capture is squashed by a mispredict
      if (cap && !mispredict) begin
        pend_v        <= 1'b1;
        pend_hint     <= cap_hint;
        pend_on_false <= cap_on_false;
        pend_tgt      <= cap_tgt;
        pend_fall     <= cap_fall;
      end
    end
  end
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter int              OFF_W      = 13,
  parameter int              INSN_BYTES = 4,
  parameter logic [31:0]     RESET_VEC  = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_valid,
  input  logic [2:0]        dec_kind,
  input  logic [PC_W-1:0]   dec_pc,
  input  logic [PC_W-1:0]   dec_abs_tgt,
  input  logic [OFF_W-1:0]  dec_off,
  input  logic              dec_hint,
  input  logic              dec_on_false,
  input  logic              res_valid,
  input  logic              cc_flag,
  output logic [PC_W-1:0]   pc_q,
  output logic [PC_W-1:0]   ret_q,
  output logic              flush_q,
  output logic              redir_q,
  output logic [PC_W-1:0]   redir_addr_q
);
  localparam logic [PC_W-1:0] STEP  = PC_W'(INSN_BYTES);
  localparam logic [PC_W-1:0] RVEC  = PC_W'(RESET_VEC);

  logic [PC_W-1:0] tgt, fall, fix_addr;
  logic            mispredict;
  logic            is_call, is_uncond, is_cond, dec_xfer, cap;

  always_comb begin
    is_call   = (xfer_kind_e'(dec_kind) == K_CALL_ABS) || (xfer_kind_e'(dec_kind) == K_CALL_REL);
    is_uncond = is_call || (xfer_kind_e'(dec_kind) == K_JMP_ABS) ||
                (xfer_kind_e'(dec_kind) == K_JMP_REL);
    is_cond   = (xfer_kind_e'(dec_kind) == K_CJMP);
    dec_xfer  = dec_valid && (is_uncond || (is_cond && dec_hint));
    cap       = dec_valid && is_cond;
  end

  npc_target #(.PC_W(PC_W), .OFF_W(OFF_W), .INSN_BYTES(INSN_BYTES)) u_target (
    .kind    (dec_kind),
    .pc_i    (dec_pc),
    .abs_tgt (dec_abs_tgt),
    .off     (dec_off),
    .tgt     (tgt),
    .fall    (fall)
  );

  npc_tracker #(.PC_W(PC_W)) u_tracker (
    .clk          (clk),
    .rst          (rst),
    .cap          (cap),
    .cap_hint     (dec_hint),
    .cap_on_false (dec_on_false),
    .cap_tgt      (tgt),
    .cap_fall     (fall),
    .res_valid    (res_valid),
    .cc_flag      (cc_flag),
    .mispredict   (mispredict),
    .fix_addr     (fix_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q         <= RVEC;
      ret_q        <= '0;
      flush_q      <= 1'b0;
      redir_q      <= 1'b0;
      redir_addr_q <= '0;
    end else if (mispredict) begin
      pc_q         <= fix_addr;
      flush_q      <= 1'b1;
      redir_q      <= 1'b1;
      redir_addr_q <= fix_addr;
    end else if (dec_xfer) begin
      pc_q         <= tgt;
      flush_q      <= 1'b0;
      redir_q      <= 1'b1;
      redir_addr_q <= tgt;
      if (is_call) ret_q <= fall;
    end else begin
      pc_q    <= pc_q + STEP;
      flush_q <= 1'b0;
      redir_q <= 1'b0;
    end
  end

  // R9
  flush_has_redir_chk: assert property (@(posedge clk) disable iff (rst)
    flush_q |-> redir_q);

  // R10
  flush_after_res_chk: assert property (@(posedge clk) disable iff (rst)
    flush_q |-> $past(res_valid));

  // R5
  ret_only_on_call_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(dec_valid && is_call) |-> $stable(ret_q));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!redir_q && !$past(rst)) |-> (pc_q == $past(pc_q) + STEP));
endmodule

// File: tb/npc_select_bench.sv
module npc_select_bench;
  localparam int CLK_P = 10;
  localparam int PC_W  = 32;
  localparam int OFF_W = 13;

  logic clk = 1'b0;
  logic rst;
  logic dec_valid, dec_hint, dec_on_false, res_valid, cc_flag;
  logic [2:0] dec_kind;
  logic [PC_W-1:0] dec_pc, dec_abs_tgt;
  logic [OFF_W-1:0] dec_off;
  logic [PC_W-1:0] pc_q, ret_q, redir_addr_q;
  logic flush_q, redir_q;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  npc_select u_npc_select (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_kind(dec_kind),
    .dec_pc(dec_pc), .dec_abs_tgt(dec_abs_tgt), .dec_off(dec_off),
    .dec_hint(dec_hint), .dec_on_false(dec_on_false),
    .res_valid(res_valid), .cc_flag(cc_flag),
    .pc_q(pc_q), .ret_q(ret_q), .flush_q(flush_q), .redir_q(redir_q),
    .redir_addr_q(redir_addr_q)
  );

  task automatic chk(input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    dec_valid = 0; dec_kind = 0; dec_pc = 0; dec_abs_tgt = 0; dec_off = 0;
    dec_hint = 0; dec_on_false = 0; res_valid = 0; cc_flag = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic dec(input logic [2:0] k, input logic [31:0] p, input logic [31:0] a,
                     input logic [12:0] o, input logic h, input logic f);
    dec_valid = 1; dec_kind = k; dec_pc = p; dec_abs_tgt = a; dec_off = o;
    dec_hint = h; dec_on_false = f;
  endtask

  task automatic resolve(input logic c);
    res_valid = 1; cc_flag = c; tick(); idle_in();
  endtask

  task automatic t_reset();
    rst = 1; idle_in(); tick(); tick();
    chk("R1 pc", pc_q, 32'h1000);
    chk("R1 ret", ret_q, 0);
    chk("R1 flush", {31'b0, flush_q}, 0);
    chk("R1 redir", {31'b0, redir_q}, 0);
    rst = 0;
  endtask

  task automatic t_seq();
    logic [31:0] p;
    p = pc_q; tick();
    chk("R2 pc", pc_q, p + 4);
    chk("R2 redir", {31'b0, redir_q}, 0);
    tick(); chk("R2 pc again", pc_q, p + 8);
  endtask

  task automatic t_jabs();
    logic [31:0] r;
    r = ret_q;
    dec(3'd1, 32'h1100, 32'h2000, 0, 0, 0); tick(); idle_in();
    chk("R3 pc", pc_q, 32'h2000);
    chk("R3 redir", {31'b0, redir_q}, 1);
    chk("R3 ret", ret_q, r);
  endtask

  task automatic t_jrel();
    dec(3'd2, 32'h3000, 0, 13'h1000, 0, 0); tick(); idle_in();
    chk("R4 min", pc_q, 32'h2000);
    dec(3'd2, 32'h3000, 0, 13'h0FFE, 0, 0); tick(); idle_in();
    chk("R4 max", pc_q, 32'h3FFE);
    dec(3'd2, 32'h3000, 0, 13'h0005, 0, 0); tick(); idle_in();
    chk("R4 odd", pc_q, 32'h3004);
  endtask

  task automatic t_call();
    dec(3'd3, 32'h4000, 32'h5000, 0, 0, 0); tick(); idle_in();
    chk("R5 abs pc", pc_q, 32'h5000);
    chk("R5 abs ret", ret_q, 32'h4004);
    dec(3'd4, 32'h6000, 0, 13'h0100, 0, 0); tick(); idle_in();
    chk("R5 rel pc", pc_q, 32'h6100);
    chk("R5 rel ret", ret_q, 32'h6004);
  endtask

  task automatic t_cond_ok();
    logic [31:0] p;
    p = pc_q;
    dec(3'd5, 32'h7000, 0, 13'h0040, 0, 0); tick(); idle_in();
    chk("R7 nt redir", {31'b0, redir_q}, 0);
    chk("R7 nt pc", pc_q, p + 4);
    resolve(0);
    chk("R8 nt flush", {31'b0, flush_q}, 0);
    chk("R8 nt redir", {31'b0, redir_q}, 0);
    dec(3'd5, 32'h7100, 0, 13'h0020, 1, 0); tick(); idle_in();
    chk("R7 t pc", pc_q, 32'h7120);
    chk("R7 t redir", {31'b0, redir_q}, 1);
    p = pc_q;
    resolve(1);
    chk("R8 t flush", {31'b0, flush_q}, 0);
    chk("R8 t pc", pc_q, p + 4);
  endtask

  task automatic t_mispredict();
    dec(3'd5, 32'h8000, 0, 13'h0080, 0, 0); tick(); idle_in();
    resolve(1);
    chk("R9 flush", {31'b0, flush_q}, 1);
    chk("R9 redir", {31'b0, redir_q}, 1);
    chk("R9 pc", pc_q, 32'h8080);
    chk("R9 addr", redir_addr_q, 32'h8080);
    tick();
    chk("R9 one cycle", {31'b0, flush_q}, 0);
    dec(3'd5, 32'h9000, 0, 13'h0010, 1, 0); tick(); idle_in();
    resolve(0);
    chk("R9 fall flush", {31'b0, flush_q}, 1);
    chk("R9 fall pc", pc_q, 32'h9004);
  endtask

  task automatic t_polarity();
    dec(3'd5, 32'hA000, 0, 13'h0030, 0, 1); tick(); idle_in();
    resolve(0);
    chk("R6 false-taken flush", {31'b0, flush_q}, 1);
    chk("R6 false-taken pc", pc_q, 32'hA030);
    dec(3'd5, 32'hA100, 0, 13'h0030, 1, 1); tick(); idle_in();
    resolve(1);
    chk("R6 true-not-taken flush", {31'b0, flush_q}, 1);
    chk("R6 true-not-taken pc", pc_q, 32'hA104);
  endtask

  task automatic t_stray();
    logic [31:0] p;
    p = pc_q;
    resolve(1);
    chk("R10 flush", {31'b0, flush_q}, 0);
    chk("R10 pc", pc_q, p + 4);
  endtask

  task automatic t_squash();
    logic [31:0] r;
    r = ret_q;
    dec(3'd5, 32'hC000, 0, 13'h0060, 0, 0); tick(); idle_in();
    dec(3'd3, 32'hC004, 32'hD000, 0, 0, 0);
    res_valid = 1; cc_flag = 1; tick(); idle_in();
    chk("R11 pc", pc_q, 32'hC060);
    chk("R11 flush", {31'b0, flush_q}, 1);
    chk("R11 ret", ret_q, r);
  endtask

  initial begin
    idle_in();
    t_reset();
    t_seq();
    t_jabs();
    t_jrel();
    t_call();
    t_cond_ok();
    t_mispredict();
    t_polarity();
    t_stray();
    t_squash();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule